// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, producing a WIDTH-bit sum and a carry-out, entirely in combinational logic. The operands are cut into 4-bit slices. Each slice forms per-bit generate and propagate terms and computes all of its internal carries directly from those terms and the slice carry-in, so no carry waits for the bit below it. Each slice also exports one group generate and one group propagate.

A second lookahead level takes the group terms and produces the carry into every slice, and the final carry-out, as flat sums of products with no chain between slices. The propagate term can be built from either the exclusive-OR or the inclusive-OR of the operand bits, selected by a parameter. The sum bits always use the exclusive-OR. WIDTH must be a multiple of four; the default is 32 bits, which gives eight slices.

The block has no clock and no state. Its results follow the operands within the same cycle, so it can sit between registers of the surrounding pipeline.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, with all three read as unsigned.
- R2: `cout_o` equals bit WIDTH of the unsigned total `a_i + b_i + cin_i`.
- R3: When every 4-bit slice has complementary operand nibbles (`b_i == ~a_i`), a carry-in of 1 travels through all slices: `sum_o` is 0 and `cout_o` is 1. With a carry-in of 0, `sum_o` is all ones and `cout_o` is 0.
- R4: A slice whose two operand nibbles already sum to 16 or more passes a carry to the next slice whatever its own carry-in is. For example, `a_i = b_i = 32'h88888888` gives `sum_o = 32'h11111110 + cin_i` and `cout_o = 1`.
- R5: The parameter `PROP_OR` picks the propagate form: 0 uses the exclusive-OR and 1 uses the inclusive-OR. Both settings give identical `sum_o` and `cout_o` for every input.
- R6: All-ones operands with `cin_i = 1` give `sum_o` equal to all ones and `cout_o = 1`. `a_i` all ones, `b_i = 0` and `cin_i = 1` give `sum_o = 0` and `cout_o = 1`.
- R7: Zero operands with `cin_i = 0` give `sum_o = 0` and `cout_o = 0`.
- R8: The outputs are a combinational function of the present inputs and hold no state: a result is valid in the same cycle its operands are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
Every result is due in the same cycle as its operands, with zero clock cycles of latency, because no register lies between the inputs and the outputs. The driver applies each operand set just after a rising edge and records the expected item. The monitor compares that item at the following falling edge, so the logic has half a period to settle and no comparison is made at an edge. The item holds the expected sum and carry-out, computed by wide behavioural addition. Both propagate variants are placed side by side and checked against the same item.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic g;
    logic p;
  } grp_term_t;
endpackage

// File: rtl/cla_slice4.sv
module cla_slice4
  import cla_pkg::*;
#(
  parameter bit PROP_OR = 1'b0
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               c_i,
  output logic [SLICE_W-1:0] s_o,
  output grp_term_t          term_o
);
  logic [SLICE_W-1:0] gen;
  logic [SLICE_W-1:0] dif;
  logic [SLICE_W-1:0] prp;
  logic [SLICE_W-1:0] cy;

  assign gen = a_i & b_i;
  assign dif = a_i ^ b_i;

  generate
    if (PROP_OR) begin : g_prop_or
      assign prp = a_i | b_i;
    end else begin : g_prop_xor
      assign prp = dif;
    end
  endgenerate

  // every internal carry is a flat sum of products
  assign cy[0] = c_i;
  assign cy[1] = gen[0] | (prp[0] & c_i);
  assign cy[2] = gen[1] | (prp[1] & gen[0]) | (prp[1] & prp[0] & c_i);
  assign cy[3] = gen[2] | (prp[2] & gen[1]) | (prp[2] & prp[1] & gen[0])
               | (prp[2] & prp[1] & prp[0] & c_i);

  // sum always from the exclusive-OR, whatever the propagate form
  assign s_o = dif ^ cy;

  assign term_o.g = gen[3] | (prp[3] & gen[2]) | (prp[3] & prp[2] & gen[1])
                  | (prp[3] & prp[2] & prp[1] & gen[0]);
  assign term_o.p = &prp;

  logic [SLICE_W:0] ref_tot;
  logic [SLICE_W:0] got_tot;
  assign ref_tot = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, c_i};
  assign got_tot = {term_o.g | (term_o.p & c_i), s_o};

  always_comb begin
    // R1
    slice_sum_chk: assert (got_tot == ref_tot)
      else $error("slice total mismatch");
    // R4
    slice_gen_chk: assert (!term_o.g || (({1'b0, a_i} + {1'b0, b_i}) >= 5'd16))
      else $error("slice generate without overflow");
    // R3
    slice_prop_chk: assert (!(term_o.p && !term_o.g) || (({1'b0, a_i} + {1'b0, b_i}) == 5'd15))
      else $error("slice propagate without full nibble");
  end
endmodule

// File: rtl/cla_group_carry.sv
module cla_group_carry
  import cla_pkg::*;
#(
  parameter int unsigned NGRP = 8
) (
  input  grp_term_t [NGRP-1:0] term_i,
  input  logic                 c0_i,
  output logic [NGRP:0]        c_o
);
  // second level: carry into each slice as an expanded sum of products
  always_comb begin
    c_o[0] = c0_i;
    for (int j = 0; j < NGRP; j++) begin
      logic acc;
      logic chain;
      chain = c0_i;
      for (int q = 0; q <= j; q++) chain = chain & term_i[q].p;
      acc = chain;
      for (int k = 0; k <= j; k++) begin
        logic prod;
        prod = term_i[k].g;
        for (int q = k + 1; q <= j; q++) prod = prod & term_i[q].p;
        acc = acc | prod;
      end
      c_o[j+1] = acc;
    end
  end

  always_comb begin
    for (int j = 0; j < NGRP; j++) begin
      // R2
      carry_link_chk: assert (c_o[j+1] == (term_i[j].g | (term_i[j].p & c_o[j])))
        else $error("group carry %0d inconsistent", j);
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter bit          PROP_OR = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NGRP = WIDTH / SLICE_W;

  grp_term_t [NGRP-1:0] terms;
  logic [NGRP:0]        gcarry;

  generate
    for (genvar gi = 0; gi < NGRP; gi++) begin : g_slice
      cla_slice4 #(.PROP_OR(PROP_OR)) u_slice (
        .a_i   (a_i[gi*SLICE_W +: SLICE_W]),
        .b_i   (b_i[gi*SLICE_W +: SLICE_W]),
        .c_i   (gcarry[gi]),
        .s_o   (sum_o[gi*SLICE_W +: SLICE_W]),
        .term_o(terms[gi])
      );
    end
  endgenerate

  cla_group_carry #(.NGRP(NGRP)) u_carry (
    .term_i(terms),
    .c0_i  (cin_i),
    .c_o   (gcarry)
  );

  assign cout_o = gcarry[NGRP];

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    // R2
    cout_top_chk: assert (cout_o == ref_total[WIDTH])
      else $error("carry-out mismatch");
    // R1
    sum_top_chk: assert (sum_o == ref_total[WIDTH-1:0])
      else $error("sum mismatch");
  end
endmodule

// File: tb/test_cla_adder.sv
`timescale 1ns/1ps
module test_cla_adder;
  localparam int unsigned W = 32;

  typedef struct {
    logic [W-1:0] sum;
    logic         cout;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic cin;
  logic [W-1:0] sum_x, sum_r;
  logic cout_x, cout_r;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #4 clk = ~clk;

  cla_adder #(.WIDTH(W), .PROP_OR(1'b0)) i_cla_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_x), .cout_o(cout_x));
  cla_adder #(.WIDTH(W), .PROP_OR(1'b1)) i_cla_adder_or (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_r), .cout_o(cout_r));

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string tag);
    item_t it;
    logic [W:0] tot;
    @(posedge clk);
    #1;
    a = av; b = bv; cin = cv;
    tot = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    it.sum = tot[W-1:0];
    it.cout = tot[W];
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: results due in the same cycle, compared at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk({it.tag, " R8 xor"}, {cout_x, sum_x}, {it.cout, it.sum});
        chk({it.tag, " R5 or-form"}, {cout_r, sum_r}, {it.cout, it.sum});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 zero inputs during reset
    chk("R7 reset zero", {cout_x, sum_x}, '0);
    rst = 1'b0;

    drive('0, '0, 1'b0, "R7");
    drive('1, '1, 1'b1, "R6 all-ones cin");
    drive('1, '0, 1'b1, "R6 wrap");
    drive(32'h5A5A_A5A5, ~32'h5A5A_A5A5, 1'b1, "R3 propagate cin1");
    drive(32'h5A5A_A5A5, ~32'h5A5A_A5A5, 1'b0, "R3 propagate cin0");
    drive(32'h8888_8888, 32'h8888_8888, 1'b0, "R4 generate");
    drive(32'h8888_8888, 32'h8888_8888, 1'b1, "R4 generate cin");
    drive('1, 32'h1, 1'b0, "R2 carry out");
    drive(32'h0000_000F, 32'h0000_0000, 1'b1, "R2 nibble carry");
    for (int i = 0; i < 300; i++) begin
      drive($urandom, $urandom, 1'($urandom), "R1 random");
    end
    wait (sb.size() == 0);
    @(negedge clk);
    // direct port check of the wrap case, R6
    @(posedge clk); #1; a = '1; b = '0; cin = 1'b1;
    @(negedge clk);
    chk("R6 direct", {cout_x, sum_x}, {1'b1, {W{1'b0}}});
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule